// File: doc/BRIEF.md
# Feedback Beam Pruning Controller

This block sits in the pruning stage of a frame-synchronous Viterbi search. Candidate arcs stream in one per cycle. Each arc carries a signed score and the number of arcs that leave its destination state. For every arc the block answers in the same cycle whether it survives. An arc survives when its score lies strictly above the best score of the previous frame minus the current beam width.

The beam width is not fixed. Within a frame the block counts the arcs it has seen and the arcs it has kept. It compares that ratio with the ratio needed to reach a target list size, given how many hypotheses the previous frame predicted. After every arc it nudges the beam by a configurable gain step toward the target, and it keeps the beam inside a configurable window. The target is sized against an active list of 4096 entries. Accepted arcs add their fan-out to a running prediction for the following frame. A one-cycle frame strobe closes a frame.

A small phase machine orders the start of a search:
- `PH_PRIME` (after reset) ignores arcs until the first strobe. That strobe loads the initial beam and enters `PH_OPEN`.
- `PH_OPEN`, the first frame, keeps every arc because there is no reference score yet. The next strobe enters `PH_STEER`.
- `PH_STEER` applies the threshold and the feedback. Every later strobe stays in `PH_STEER`.

Top module: `beam_pruner`

## Requirements
- R1: After reset the beam width is 0, the reported frame maximum is the most negative score (-2048 at the default 12-bit width), and the block is in `PH_PRIME`. Arcs presented before the first frame strobe are rejected and do not enter the maximum.
- R2: The first strobe loads the configured initial beam, clamped into [min, max]. During the first frame (`PH_OPEN`) every arc is accepted and the beam is not steered.
- R3: In `PH_STEER` an arc is accepted exactly when its signed score is strictly greater than frame maximum minus beam width. This difference is evaluated without wrap-around, even when the maximum is the most negative score.
- R4: At each strobe the reported frame maximum becomes the highest score among the arcs processed since the previous strobe, or the most negative score if there were none. It changes at no other time.
- R5: An arc presented in the same cycle as the strobe is dropped. It is not accepted, not counted, and not included in the maximum.
- R6: After each processed arc in `PH_STEER`, the block forms kept×expected and target×seen. Both counts include that arc, and expected is the value latched at the last strobe. The beam grows by the gain when kept×expected is smaller, shrinks by the gain when it is larger, and holds when the two are equal. The new beam applies from the next arc on.
- R7: Every beam update is clamped: a result above the maximum becomes the maximum, and a result below the minimum becomes the minimum.
- R8: With gain 0 the beam never changes, except for the load at the first strobe.
- R9: The expected count is the sum of the fan-out values of the arcs accepted in a frame. It is latched at the strobe for use during the next frame. The kept, seen and running expected counts clear at every strobe.
- R10: The accept output is combinational on the arc inputs, valid in the same cycle, and low whenever no arc is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe closing the current frame |
| arc_valid | input | 1 | An arc is presented this cycle |
| arc_score | input | SCORE_W (12) | Signed arc score |
| arc_fanout | input | FAN_W (4) | Outgoing-arc count of the arc's destination state |
| cfg_target | input | CNT_W (13) | Desired number of kept arcs per frame |
| cfg_gain | input | GAIN_W (4) | Beam step per arc |
| cfg_beam_init | input | BEAM_W (8) | Beam loaded at the first strobe |
| cfg_beam_min | input | BEAM_W (8) | Lower beam clamp |
| cfg_beam_max | input | BEAM_W (8) | Upper beam clamp |
| arc_accept | output | 1 | Keep decision for the presented arc |
| beam_width | output | BEAM_W (8) | Current beam width |
| frame_max | output | SCORE_W (12) | Best score of the previous frame |

## Verification
The assertions check the following on every cycle:
- no accept appears without an arc, during the strobe, or in `PH_PRIME`;
- every arc in `PH_OPEN` is kept;
- the frame maximum only moves at a strobe;
- a zero gain freezes the beam;
- every steering step lands inside the clamp window.

The exact direction of each beam step depends on the cross-multiplied ratio and the latched fan-out sum, and so does the strict comparison at the threshold edge. Only the bench scenarios show these. The bench sweeps scores across the threshold, streams pseudo-random arcs under several targets that drive the beam into both clamps, and replays empty frames.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        PH_PRIME = 2'd0,
        PH_OPEN  = 2'd1,
        PH_STEER = 2'd2
    } phase_t;
endpackage

// File: rtl/bwc_phase_fsm.sv
module bwc_phase_fsm
    import bwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_start,
    output phase_t phase,
    output logic   load_init,
    output logic   open_en,
    output logic   steer_en
);
    phase_t phase_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_PRIME;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_PRIME: if (frame_start) phase_nx = PH_OPEN;
            PH_OPEN:  if (frame_start) phase_nx = PH_STEER;
            PH_STEER: phase_nx = PH_STEER;
            default:  phase_nx = PH_PRIME;
        endcase
    end

    always_comb begin
        load_init = 1'b0;
        open_en   = 1'b0;
        steer_en  = 1'b0;
        unique case (phase)
            PH_PRIME: load_init = frame_start;
            PH_OPEN:  open_en   = 1'b1;
            PH_STEER: steer_en  = 1'b1;
            default:  load_init = 1'b0;
        endcase
    end
endmodule

// File: rtl/bwc_frame_stats.sv
module bwc_frame_stats #(
    parameter int SCORE_W = 12,
    parameter int FAN_W   = 4,
    parameter int CNT_W   = 13,
    parameter int EXP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               live,
    input  logic               accept,
    input  logic [SCORE_W-1:0] score,
    input  logic [FAN_W-1:0]   fanout,
    output logic [SCORE_W-1:0] prev_max,
    output logic [CNT_W-1:0]   acc_nx,
    output logic [CNT_W-1:0]   proc_nx,
    output logic [EXP_W-1:0]   exp_lat
);
    localparam logic [SCORE_W-1:0] S_MIN   = {1'b1, {(SCORE_W-1){1'b0}}};
    localparam logic [CNT_W-1:0]   CNT_TOP = {CNT_W{1'b1}};

    logic [SCORE_W-1:0] cur_max;
    logic [CNT_W-1:0]   acc_q, proc_q;
    logic [EXP_W-1:0]   exp_run;
    logic [EXP_W:0]     exp_sum;
    logic [EXP_W-1:0]   exp_nx;

    always_comb begin
        proc_nx = (proc_q == CNT_TOP) ? proc_q : proc_q + CNT_W'(1);
        acc_nx  = (accept && acc_q != CNT_TOP) ? acc_q + CNT_W'(1) : acc_q;
        exp_sum = {1'b0, exp_run} + (EXP_W+1)'(fanout);
        exp_nx  = exp_sum[EXP_W] ? {EXP_W{1'b1}} : exp_sum[EXP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_max  <= S_MIN;
            prev_max <= S_MIN;
            acc_q    <= '0;
            proc_q   <= '0;
            exp_run  <= '0;
            exp_lat  <= '0;
        end else if (frame_start) begin
            prev_max <= cur_max;
            cur_max  <= S_MIN;
            acc_q    <= '0;
            proc_q   <= '0;
            exp_run  <= '0;
            exp_lat  <= exp_run;
        end else if (live) begin
            if ($signed(score) > $signed(cur_max)) cur_max <= score;
            proc_q <= proc_nx;
            acc_q  <= acc_nx;
            if (accept) exp_run <= exp_nx;
        end
    end
endmodule

// File: rtl/bwc_beam_ctl.sv
module bwc_beam_ctl #(
    parameter int BEAM_W = 8,
    parameter int GAIN_W = 4,
    parameter int CNT_W  = 13,
    parameter int EXP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_init,
    input  logic              steer_upd,
    input  logic [CNT_W-1:0]  acc_nx,
    input  logic [CNT_W-1:0]  proc_nx,
    input  logic [EXP_W-1:0]  exp_lat,
    input  logic [CNT_W-1:0]  target,
    input  logic [GAIN_W-1:0] gain,
    input  logic [BEAM_W-1:0] beam_init,
    input  logic [BEAM_W-1:0] beam_min,
    input  logic [BEAM_W-1:0] beam_max,
    output logic [BEAM_W-1:0] beam
);
    localparam int PW = CNT_W + EXP_W;
    localparam int VW = BEAM_W + 2;

    logic [PW-1:0] have_p, want_p;
    logic [VW-1:0] up_v, dn_v, step_v;

    function automatic logic [BEAM_W-1:0] clampv(
        input logic [VW-1:0]     v,
        input logic [BEAM_W-1:0] lo,
        input logic [BEAM_W-1:0] hi
    );
        if ($signed(v) > $signed({2'b00, hi}))      return hi;
        else if ($signed(v) < $signed({2'b00, lo})) return lo;
        else                                        return v[BEAM_W-1:0];
    endfunction

    always_comb begin
        have_p = PW'(acc_nx) * PW'(exp_lat);
        want_p = PW'(target) * PW'(proc_nx);
        up_v   = {2'b00, beam} + VW'(gain);
        dn_v   = {2'b00, beam} - VW'(gain);
        if (have_p < want_p)      step_v = up_v;
        else if (have_p > want_p) step_v = dn_v;
        else                      step_v = {2'b00, beam};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            beam <= '0;
        else if (load_init)
            beam <= clampv({2'b00, beam_init}, beam_min, beam_max);
        else if (steer_upd && gain != '0)
            beam <= clampv(step_v, beam_min, beam_max);
    end
endmodule

// File: rtl/beam_pruner.sv
module beam_pruner
    import bwc_pkg::*;
#(
    parameter int SCORE_W = 12,
    parameter int FAN_W   = 4,
    parameter int CNT_W   = 13,
    parameter int EXP_W   = 16,
    parameter int BEAM_W  = 8,
    parameter int GAIN_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               arc_valid,
    input  logic [SCORE_W-1:0] arc_score,
    input  logic [FAN_W-1:0]   arc_fanout,
    input  logic [CNT_W-1:0]   cfg_target,
    input  logic [GAIN_W-1:0]  cfg_gain,
    input  logic [BEAM_W-1:0]  cfg_beam_init,
    input  logic [BEAM_W-1:0]  cfg_beam_min,
    input  logic [BEAM_W-1:0]  cfg_beam_max,
    output logic               arc_accept,
    output logic [BEAM_W-1:0]  beam_width,
    output logic [SCORE_W-1:0] frame_max
);
    localparam int XW = SCORE_W + 2;

    phase_t            phase;
    logic              load_init, open_en, steer_en;
    logic              live, above;
    logic [XW-1:0]     score_x, thresh_x;
    logic [CNT_W-1:0]  acc_nx, proc_nx;
    logic [EXP_W-1:0]  exp_lat;

    bwc_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .phase      (phase),
        .load_init  (load_init),
        .open_en    (open_en),
        .steer_en   (steer_en)
    );

    always_comb begin
        live     = arc_valid && !frame_start && (open_en || steer_en);
        score_x  = {{2{arc_score[SCORE_W-1]}}, arc_score};
        thresh_x = {{2{frame_max[SCORE_W-1]}}, frame_max}
                 - {{(XW-BEAM_W){1'b0}}, beam_width};
        above    = $signed(score_x) > $signed(thresh_x);
        arc_accept = live && (open_en || above);
    end

    bwc_frame_stats #(
        .SCORE_W(SCORE_W), .FAN_W(FAN_W), .CNT_W(CNT_W), .EXP_W(EXP_W)
    ) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .live       (live),
        .accept     (arc_accept),
        .score      (arc_score),
        .fanout     (arc_fanout),
        .prev_max   (frame_max),
        .acc_nx     (acc_nx),
        .proc_nx    (proc_nx),
        .exp_lat    (exp_lat)
    );

    bwc_beam_ctl #(
        .BEAM_W(BEAM_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .EXP_W(EXP_W)
    ) u_beam (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_init(load_init),
        .steer_upd(live && steer_en),
        .acc_nx   (acc_nx),
        .proc_nx  (proc_nx),
        .exp_lat  (exp_lat),
        .target   (cfg_target),
        .gain     (cfg_gain),
        .beam_init(cfg_beam_init),
        .beam_min (cfg_beam_min),
        .beam_max (cfg_beam_max),
        .beam     (beam_width)
    );
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk
    import bwc_pkg::*;
#(
    parameter int SCORE_W = 12,
    parameter int BEAM_W  = 8,
    parameter int GAIN_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               arc_valid,
    input logic               arc_accept,
    input logic [GAIN_W-1:0]  cfg_gain,
    input logic [BEAM_W-1:0]  cfg_beam_min,
    input logic [BEAM_W-1:0]  cfg_beam_max,
    input logic [BEAM_W-1:0]  beam_width,
    input logic [SCORE_W-1:0] frame_max,
    input phase_t             phase,
    input logic               load_init
);
    // R10
    accept_needs_arc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arc_accept |-> arc_valid);

    // R5
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !arc_accept);

    // R1
    prime_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRIME) |-> !arc_accept);

    // R2
    open_take_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPEN && arc_valid && !frame_start) |-> arc_accept);

    // R4
    max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_max));

    // R8
    gain_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gain == '0 && !load_init) |=> $stable(beam_width));

    // R7
    step_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_STEER && arc_valid && !frame_start && cfg_gain != '0) || load_init)
        |=> (beam_width >= $past(cfg_beam_min) && beam_width <= $past(cfg_beam_max)));
endmodule

bind beam_pruner bwc_chk #(
    .SCORE_W(SCORE_W), .BEAM_W(BEAM_W), .GAIN_W(GAIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .arc_valid   (arc_valid),
    .arc_accept  (arc_accept),
    .cfg_gain    (cfg_gain),
    .cfg_beam_min(cfg_beam_min),
    .cfg_beam_max(cfg_beam_max),
    .beam_width  (beam_width),
    .frame_max   (frame_max),
    .phase       (phase),
    .load_init   (load_init)
);

// File: tb/sim_beam_pruner.sv
`timescale 1ns/1ps
module sim_beam_pruner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        arc_valid = 1'b0;
    logic [11:0] arc_score = '0;
    logic [3:0]  arc_fanout = '0;
    logic [12:0] cfg_target = '0;
    logic [3:0]  cfg_gain = '0;
    logic [7:0]  cfg_beam_init = '0;
    logic [7:0]  cfg_beam_min = '0;
    logic [7:0]  cfg_beam_max = '0;
    logic        arc_accept;
    logic [7:0]  beam_width;
    logic [11:0] frame_max;

    beam_pruner u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .arc_valid(arc_valid), .arc_score(arc_score), .arc_fanout(arc_fanout),
        .cfg_target(cfg_target), .cfg_gain(cfg_gain),
        .cfg_beam_init(cfg_beam_init), .cfg_beam_min(cfg_beam_min),
        .cfg_beam_max(cfg_beam_max), .arc_accept(arc_accept),
        .beam_width(beam_width), .frame_max(frame_max)
    );

    always #2.5 clk = ~clk;

    localparam int SMIN = -2048;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_phase, m_prev, m_cur, m_acc, m_proc, m_exp, m_exp_lat, m_beam;
    bit [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampm(input int v);
        int lo = int'(cfg_beam_min);
        int hi = int'(cfg_beam_max);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic bit m_accept(input int s);
        if (m_phase == 0) return 1'b0;
        if (m_phase == 1) return 1'b1;
        return s > (m_prev - m_beam);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_start = 1'b0; arc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_phase = 0; m_prev = SMIN; m_cur = SMIN; m_acc = 0; m_proc = 0;
        m_exp = 0; m_exp_lat = 0; m_beam = 0;
        #1;
        chk(int'(beam_width) == 0, "R1 reset beam", int'(beam_width), 0);
        chk(int'($signed(frame_max)) == SMIN, "R1 reset max", int'($signed(frame_max)), SMIN);
    endtask

    task automatic arc(input int s, input int f, input string req);
        bit ea;
        @(negedge clk);
        arc_valid = 1'b1; arc_score = s[11:0]; arc_fanout = f[3:0];
        #1;
        ea = m_accept(s);
        chk(arc_accept == ea, req, int'(arc_accept), int'(ea));
        @(posedge clk);
        if (m_phase != 0) begin
            if (s > m_cur) m_cur = s;
            m_proc++;
            if (ea) begin m_acc++; m_exp += f; end
            if (m_phase == 2 && cfg_gain != 0) begin
                longint have = longint'(m_acc) * m_exp_lat;
                longint want = longint'(cfg_target) * m_proc;
                int v = m_beam;
                if (have < want) v = m_beam + int'(cfg_gain);
                else if (have > want) v = m_beam - int'(cfg_gain);
                m_beam = clampm(v);
            end
        end
        #1;
        arc_valid = 1'b0;
        chk(int'(beam_width) == m_beam, {req, " beam"}, int'(beam_width), m_beam);
    endtask

    task automatic frame(input bit with_arc, input int s);
        @(negedge clk);
        frame_start = 1'b1; arc_valid = with_arc; arc_score = s[11:0]; arc_fanout = 4'd9;
        #1;
        chk(arc_accept == 1'b0, "R5 strobe arc dropped", int'(arc_accept), 0);
        @(posedge clk);
        m_exp_lat = m_exp; m_exp = 0; m_acc = 0; m_proc = 0;
        m_prev = m_cur; m_cur = SMIN;
        if (m_phase == 0) begin m_beam = clampm(int'(cfg_beam_init)); m_phase = 1; end
        else m_phase = 2;
        #1;
        frame_start = 1'b0; arc_valid = 1'b0;
        chk(int'($signed(frame_max)) == m_prev, "R4 frame max", int'($signed(frame_max)), m_prev);
        chk(int'(beam_width) == m_beam, "R2 beam after strobe", int'(beam_width), m_beam);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_target = 13'd6; cfg_gain = 4'd0; cfg_beam_init = 8'd40;
        cfg_beam_min = 8'd10; cfg_beam_max = 8'd200;
        do_reset();

        // R1: arcs before the first strobe are rejected and leave no trace
        arc(2000, 5, "R1 prime reject");
        arc(-100, 5, "R1 prime reject");
        // R10: accept low with no arc
        @(negedge clk); #1;
        chk(arc_accept == 1'b0, "R10 idle accept", int'(arc_accept), 0);

        frame(1'b0, 0);   // R2 load beam, R4 max stays minimum
        // R2: open frame keeps everything, beam fixed
        for (int k = 0; k < 64; k++) arc(SMIN + k * 64, k % 4, "R2 open accept");
        // R5: strobe arc with big score must not reach the maximum
        frame(1'b1, 2047);

        // R3 and R8: sweep across the threshold edge with zero gain
        for (int s = 1930; s <= 1960; s++) arc(s, s % 4, "R3 threshold sweep");
        frame(1'b0, 0);

        // R6, R7, R9: steering under several targets
        cfg_gain = 4'd3; cfg_beam_min = 8'd20; cfg_beam_max = 8'd60;
        for (int fr = 0; fr < 4; fr++) begin
            cfg_target = (fr == 0) ? 13'd10 : (fr == 1) ? 13'd200 : (fr == 2) ? 13'd2 : 13'd40;
            for (int k = 0; k < 100; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                arc(1780 + int'(seed[23:16]), int'(seed[11:8]), "R6 steering");
            end
            frame(1'b0, 0);
        end
        // R7: large gain pins to each clamp
        cfg_gain = 4'd15; cfg_target = 13'd4000;
        for (int k = 0; k < 6; k++) arc(2000, 15, "R7 clamp high");
        cfg_target = 13'd0;
        for (int k = 0; k < 6; k++) arc(2000, 15, "R7 clamp low");

        // R4/R3: empty frame leaves minimum; lowest score passes with no wrap
        frame(1'b0, 0);
        frame(1'b0, 0);
        cfg_gain = 4'd0;
        arc(SMIN, 1, "R3 no wrap at minimum");
        arc(SMIN + 5, 1, "R3 no wrap at minimum");

        // R2/R7: initial beam clamped into the window
        cfg_beam_init = 8'd250; cfg_beam_min = 8'd10; cfg_beam_max = 8'd200;
        do_reset();
        frame(1'b0, 0);
        chk(int'(beam_width) == 200, "R7 init clamp high", int'(beam_width), 200);
        cfg_beam_init = 8'd5;
        do_reset();
        frame(1'b0, 0);
        chk(int'(beam_width) == 10, "R7 init clamp low", int'(beam_width), 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule